// File: doc/BRIEF.md
# Asynchronous Fault Status Capture Register

This block gathers asynchronous hardware error reports into one 64-bit status word that software polls and clears. Each incoming report names one of nineteen error types. It also carries the physical address involved, a 4-bit memory-tag syndrome, a 9-bit data ECC syndrome, the processor privilege level, and a tag and 16-byte beat index when it belongs to a 64-byte bus transaction. Every error type owns one sticky bit. Software clears a sticky bit by writing a one to it. Reads have no side effects.

A single fault-address register and the two syndrome fields each hold one event at a time. A capture locks when it is taken and can be replaced only by an event of a strictly higher class. The classes, from highest to lowest, are uncorrectable, software-correctable and hardware-corrected. A capture unlocks as soon as the sticky bit of the event it holds is cleared, even if other sticky bits are still set. The register also has a multiple-error flag, a privilege capture bit and a level interrupt output.

Reports arrive on a valid/ready stream. The block takes one report per cycle and never applies back-pressure, so `evt_ready` is held high. A report counts as transferred in any cycle where `evt_valid` is high. The software write port and the interrupt pins are plain signals.

Top module: `fault_status_reg`

## Requirements
- R1: A report of type t, with t from 0 to 18, sets status bit 33+t one cycle after the transfer. A report with a type of 19 or more changes nothing.
- R2: Writing a one to any of bits 53, 52 or 51:33 clears that bit. Writing a zero leaves the bit unchanged. Reading never clears anything.
- R3: The data syndrome field is bits 8:0 and the memory-tag syndrome field is bits 19:16. Software writes to either field are ignored. The data field captures reports of types 0 to 9, 12 and 13. The tag field captures reports of types 14 and 15.
- R4: Bit 53 (multiple-error) is set when a report of an uncorrectable or software-correctable type arrives while its own sticky bit is already set. Types 0, 3, 5, 7, 13 and 15 are hardware-corrected. Type 9 is software-correctable. All other types are uncorrectable.
- R5: A repeat of a hardware-corrected type does not set bit 53. Neither does a report of a type different from the bits already set.
- R6: A bus report whose tag matches the transaction last logged, and whose beat index is greater than the beat that was logged, is dropped. It sets no bit and moves no capture. A beat that is not greater starts a new transaction.
- R7: Bit 52 takes the privilege input of every logged report.
- R8: An unlocked capture takes the next eligible report. A locked capture is overwritten only by a report of a strictly higher class.
- R9: A capture unlocks once the sticky bit of the event it holds is cleared, even if other sticky bits remain set. The captured value is held until a later report is taken.
- R10: If a report and a software clear hit the same sticky bit in the same cycle, the report wins. The bit stays set and the captures follow the report.
- R11: `irq` is high exactly when any of bits 51:33 is set and `irq_en` is high.
- R12: Reset clears every status bit, the address and the syndromes, and unlocks all captures. `evt_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error report present |
| evt_ready | output | 1 | Report accepted (always high) |
| evt_type | input | 5 | Error type index |
| evt_addr | input | ADDR_W | Physical address of the fault |
| evt_msyn | input | 4 | Memory-tag ECC syndrome |
| evt_esyn | input | 9 | Data ECC syndrome |
| evt_priv | input | 1 | Privilege level at detection |
| evt_bus | input | 1 | Report belongs to a 64-byte bus transaction |
| evt_tag | input | TAG_W | Bus transaction tag |
| evt_beat | input | 2 | 16-byte subunit index within the transaction |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 64 | Write-one-to-clear data |
| sw_rd_data | output | 64 | Status word |
| fault_addr | output | ADDR_W | Captured fault address |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Level interrupt |

## Verification
Each report or write is registered once, so every status bit, syndrome field and the captured address reflect it one clock edge later. The interrupt follows the sticky bits combinationally, so it changes on that same edge, and it follows `irq_en` with no delay. The bench drives every stimulus on a falling edge for exactly one rising edge and samples on the next falling edge. For the interrupt enable alone it samples a moment after the enable changes.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int NUM_ERR   = 19;
  localparam int IDX_W     = $clog2(NUM_ERR);
  localparam int STICKY_LO = 33;
  localparam int STICKY_HI = STICKY_LO + NUM_ERR - 1;
  localparam int PRIV_BIT  = 52;
  localparam int ME_BIT    = 53;
  localparam int ESYN_LO   = 0;
  localparam int ESYN_W    = 9;
  localparam int MSYN_LO   = 16;
  localparam int MSYN_W    = 4;
  localparam int REG_W     = 64;

  // class membership per type index
  localparam logic [NUM_ERR-1:0] HWC_MASK  = 19'h0A0A9;
  localparam logic [NUM_ERR-1:0] SWC_MASK  = 19'h00200;
  localparam logic [NUM_ERR-1:0] MTAG_MASK = 19'h0C000;
  localparam logic [NUM_ERR-1:0] DSYN_MASK = 19'h033FF;
  localparam logic [NUM_ERR-1:0] ADDR_MASK = {NUM_ERR{1'b1}};

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_HWC  = 2'd1,
    CLS_SWC  = 2'd2,
    CLS_UNC  = 2'd3
  } fsr_cls_e;

  function automatic fsr_cls_e cls_of(input logic [IDX_W-1:0] idx);
    logic [(1<<IDX_W)-1:0] hw_ext;
    logic [(1<<IDX_W)-1:0] sw_ext;
    hw_ext = (1<<IDX_W)'(HWC_MASK);
    sw_ext = (1<<IDX_W)'(SWC_MASK);
    if (hw_ext[idx])      return CLS_HWC;
    else if (sw_ext[idx]) return CLS_SWC;
    else                  return CLS_UNC;
  endfunction
endpackage

// File: rtl/fsr_txn_filter.sv
module fsr_txn_filter #(
  parameter int TAG_W  = 4,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic              chk_bus,
  input  logic [TAG_W-1:0]  chk_tag,
  input  logic [BEAT_W-1:0] chk_beat,
  output logic              drop
);
  logic              trk_vld;
  logic [TAG_W-1:0]  trk_tag;
  logic [BEAT_W-1:0] trk_beat;

  always_comb begin
    drop = chk_bus && trk_vld && (chk_tag == trk_tag) && (chk_beat > trk_beat);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_vld  <= 1'b0;
      trk_tag  <= '0;
      trk_beat <= '0;
    end else if (chk_valid && chk_bus && !drop) begin
      trk_vld  <= 1'b1;
      trk_tag  <= chk_tag;
      trk_beat <= chk_beat;
    end
  end
endmodule

// File: rtl/fsr_capture.sv
module fsr_capture
  import fsr_pkg::*;
#(
  parameter int                 DW   = 8,
  parameter logic [NUM_ERR-1:0] ELIG = {NUM_ERR{1'b1}}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               log_en,
  input  logic [IDX_W-1:0]   log_idx,
  input  fsr_cls_e           log_cls,
  input  logic [DW-1:0]      log_data,
  input  logic               clr_en,
  input  logic [NUM_ERR-1:0] clr_mask,
  output logic [DW-1:0]      cap_data
);
  localparam int EXT = 1 << IDX_W;

  logic [EXT-1:0]   elig_ext;
  logic [EXT-1:0]   clr_ext;
  logic             locked;
  logic [IDX_W-1:0] own_idx;
  fsr_cls_e         own_cls;
  logic             clr_hit;
  logic             still_locked;
  logic             take;

  always_comb begin
    elig_ext     = EXT'(ELIG);
    clr_ext      = EXT'(clr_mask);
    clr_hit      = clr_en && locked && clr_ext[own_idx];
    still_locked = locked && !clr_hit;
    take         = log_en && elig_ext[log_idx] &&
                   (!still_locked || (log_cls > own_cls));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      own_idx  <= '0;
      own_cls  <= CLS_NONE;
      cap_data <= '0;
    end else if (take) begin
      locked   <= 1'b1;
      own_idx  <= log_idx;
      own_cls  <= log_cls;
      cap_data <= log_data;
    end else if (clr_hit) begin
      locked   <= 1'b0;
      own_cls  <= CLS_NONE;
    end
  end
endmodule

// File: rtl/fsr_sticky_bank.sv
module fsr_sticky_bank
  import fsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               log_en,
  input  logic [IDX_W-1:0]   log_idx,
  input  fsr_cls_e           log_cls,
  input  logic               log_priv,
  input  logic               clr_en,
  input  logic [NUM_ERR-1:0] clr_sticky,
  input  logic               clr_me,
  input  logic               clr_priv,
  output logic [NUM_ERR-1:0] sticky,
  output logic               me_flag,
  output logic               priv_flag
);
  localparam int EXT = 1 << IDX_W;

  logic [EXT-1:0]     sticky_ext;
  logic [EXT-1:0]     set_ext;
  logic [NUM_ERR-1:0] set_vec;
  logic [NUM_ERR-1:0] clr_vec;
  logic               repeat_hit;

  always_comb begin
    sticky_ext = EXT'(sticky);
    set_ext    = log_en ? (EXT'(1) << log_idx) : '0;
    set_vec    = set_ext[NUM_ERR-1:0];
    clr_vec    = clr_en ? clr_sticky : '0;
    repeat_hit = log_en && sticky_ext[log_idx] && (log_cls != CLS_HWC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky    <= '0;
      me_flag   <= 1'b0;
      priv_flag <= 1'b0;
    end else begin
      sticky  <= (sticky & ~clr_vec) | set_vec;
      me_flag <= (me_flag && !(clr_en && clr_me)) || repeat_hit;
      if (log_en)                 priv_flag <= log_priv;
      else if (clr_en && clr_priv) priv_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int TAG_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  output logic                 evt_ready,
  input  logic [IDX_W-1:0]     evt_type,
  input  logic [ADDR_W-1:0]    evt_addr,
  input  logic [MSYN_W-1:0]    evt_msyn,
  input  logic [ESYN_W-1:0]    evt_esyn,
  input  logic                 evt_priv,
  input  logic                 evt_bus,
  input  logic [TAG_W-1:0]     evt_tag,
  input  logic [1:0]           evt_beat,
  input  logic                 sw_wr_en,
  input  logic [REG_W-1:0]     sw_wr_data,
  output logic [REG_W-1:0]     sw_rd_data,
  output logic [ADDR_W-1:0]    fault_addr,
  input  logic                 irq_en,
  output logic                 irq
);
  logic               xfer;
  logic               type_ok;
  logic               drop;
  logic               log_en;
  fsr_cls_e           log_cls;
  logic [NUM_ERR-1:0] clr_sticky;
  logic [NUM_ERR-1:0] sticky;
  logic               me_flag;
  logic               priv_flag;
  logic [MSYN_W-1:0]  msyn_q;
  logic [ESYN_W-1:0]  esyn_q;

  assign evt_ready = 1'b1;

  always_comb begin
    xfer       = evt_valid && evt_ready;
    type_ok    = (int'(evt_type) < NUM_ERR);
    log_en     = xfer && type_ok && !drop;
    log_cls    = cls_of(evt_type);
    clr_sticky = sw_wr_data[STICKY_HI:STICKY_LO];
  end

  fsr_txn_filter #(.TAG_W(TAG_W), .BEAT_W(2)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (xfer && type_ok),
    .chk_bus   (evt_bus),
    .chk_tag   (evt_tag),
    .chk_beat  (evt_beat),
    .drop      (drop)
  );

  fsr_sticky_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .log_en     (log_en),
    .log_idx    (evt_type),
    .log_cls    (log_cls),
    .log_priv   (evt_priv),
    .clr_en     (sw_wr_en),
    .clr_sticky (clr_sticky),
    .clr_me     (sw_wr_data[ME_BIT]),
    .clr_priv   (sw_wr_data[PRIV_BIT]),
    .sticky     (sticky),
    .me_flag    (me_flag),
    .priv_flag  (priv_flag)
  );

  fsr_capture #(.DW(ADDR_W), .ELIG(ADDR_MASK)) u_cap_addr (
    .clk (clk), .rst_n (rst_n), .log_en (log_en), .log_idx (evt_type),
    .log_cls (log_cls), .log_data (evt_addr), .clr_en (sw_wr_en),
    .clr_mask (clr_sticky), .cap_data (fault_addr)
  );

  fsr_capture #(.DW(MSYN_W), .ELIG(MTAG_MASK)) u_cap_msyn (
    .clk (clk), .rst_n (rst_n), .log_en (log_en), .log_idx (evt_type),
    .log_cls (log_cls), .log_data (evt_msyn), .clr_en (sw_wr_en),
    .clr_mask (clr_sticky), .cap_data (msyn_q)
  );

  fsr_capture #(.DW(ESYN_W), .ELIG(DSYN_MASK)) u_cap_esyn (
    .clk (clk), .rst_n (rst_n), .log_en (log_en), .log_idx (evt_type),
    .log_cls (log_cls), .log_data (evt_esyn), .clr_en (sw_wr_en),
    .clr_mask (clr_sticky), .cap_data (esyn_q)
  );

  always_comb begin
    sw_rd_data = '0;
    sw_rd_data[ME_BIT]                         = me_flag;
    sw_rd_data[PRIV_BIT]                       = priv_flag;
    sw_rd_data[STICKY_HI:STICKY_LO]            = sticky;
    sw_rd_data[MSYN_LO+MSYN_W-1:MSYN_LO]       = msyn_q;
    sw_rd_data[ESYN_LO+ESYN_W-1:ESYN_LO]       = esyn_q;
    irq = irq_en && (|sticky);
  end
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic [IDX_W-1:0]  evt_type,
  input logic              evt_bus,
  input logic              sw_wr_en,
  input logic [REG_W-1:0]  sw_rd_data,
  input logic [ADDR_W-1:0] fault_addr,
  input logic              irq_en,
  input logic              irq
);
  AST_EVT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_bus && int'(evt_type) < NUM_ERR) |=>
      sw_rd_data[STICKY_LO + int'($past(evt_type))]); // R1

  AST_NO_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !sw_wr_en) |=> (sw_rd_data == $past(sw_rd_data))); // R2

  AST_SYND_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> (sw_rd_data[19:16] == $past(sw_rd_data[19:16]) &&
                    sw_rd_data[8:0] == $past(sw_rd_data[8:0]))); // R3

  AST_ME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd_data[ME_BIT] && !sw_wr_en) |=> sw_rd_data[ME_BIT]); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> (fault_addr == $past(fault_addr))); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R11
endmodule

bind fault_status_reg fsr_checker #(.ADDR_W(ADDR_W)) u_fsr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_valid  (evt_valid),
  .evt_type   (evt_type),
  .evt_bus    (evt_bus),
  .sw_wr_en   (sw_wr_en),
  .sw_rd_data (sw_rd_data),
  .fault_addr (fault_addr),
  .irq_en     (irq_en),
  .irq        (irq)
);

// File: tb/tb_fault_status_reg.sv
module tb_fault_status_reg;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 40;
  localparam int TAG_W = 4;
  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              evt_valid;
  logic              evt_ready;
  logic [4:0]        evt_type;
  logic [ADDR_W-1:0] evt_addr;
  logic [3:0]        evt_msyn;
  logic [8:0]        evt_esyn;
  logic              evt_priv;
  logic              evt_bus;
  logic [TAG_W-1:0]  evt_tag;
  logic [1:0]        evt_beat;
  logic              sw_wr_en;
  logic [63:0]       sw_wr_data;
  logic [63:0]       sw_rd_data;
  logic [ADDR_W-1:0] fault_addr;
  logic              irq_en;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_status_reg #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) dut (.*);

  // class tables as stated in the requirements
  function automatic bit is_hw(input int t);
    return (t == 0 || t == 3 || t == 5 || t == 7 || t == 13 || t == 15);
  endfunction
  function automatic int cls(input int t);
    if (is_hw(t)) return 1;
    if (t == 9) return 2;
    return 3;
  endfunction
  function automatic bit is_dsyn(input int t);
    return (t <= 9 || t == 12 || t == 13);
  endfunction
  function automatic bit is_mtag(input int t);
    return (t == 14 || t == 15);
  endfunction
  function automatic logic [ADDR_W-1:0] addr_of(input int t, input int k);
    return ADDR_W'(64'h10_0000_0000 + t * 256 + k);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input int t, input logic [ADDR_W-1:0] a,
                      input logic [3:0] ms, input logic [8:0] es, input bit pr,
                      input bit bus, input logic [TAG_W-1:0] tag, input logic [1:0] beat,
                      input bit w, input logic [63:0] wd);
    evt_valid = v; evt_type = 5'(t); evt_addr = a; evt_msyn = ms; evt_esyn = es;
    evt_priv = pr; evt_bus = bus; evt_tag = tag; evt_beat = beat;
    sw_wr_en = w; sw_wr_data = wd;
    @(posedge clk);
    @(negedge clk);
    evt_valid = 1'b0; sw_wr_en = 1'b0; sw_wr_data = '0;
  endtask

  task automatic evt(input int t, input logic [ADDR_W-1:0] a);
    step(1, t, a, 4'h0, 9'h0, 0, 0, '0, 2'd0, 0, '0);
  endtask
  task automatic wr(input logic [63:0] d);
    step(0, 0, '0, 4'h0, 9'h0, 0, 0, '0, 2'd0, 1, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0]  exp_ms;
    logic [8:0]  exp_es;
    logic [63:0] snap;
    logic [ADDR_W-1:0] asnap;
    rst_n = 1'b0; irq_en = 1'b1;
    evt_valid = 0; evt_type = 0; evt_addr = 0; evt_msyn = 0; evt_esyn = 0;
    evt_priv = 0; evt_bus = 0; evt_tag = 0; evt_beat = 0; sw_wr_en = 0; sw_wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset status", sw_rd_data, 64'h0);
    check("R12 reset addr", 64'(fault_addr), 64'h0);
    check("R12 reset irq", 64'(irq), 64'h0);
    check("R12 ready", 64'(evt_ready), 64'h1);

    // sweep each type: set, syndrome capture, zero/syndrome writes, clear
    exp_ms = 0; exp_es = 0;
    for (int i = 0; i < 19; i++) begin
      logic [3:0] ms; logic [8:0] es;
      ms = 4'((i % 15) + 1); es = 9'((i * 37 + 3) & 511);
      wr(ALL1);
      step(1, i, addr_of(i, 1), ms, es, 0, 0, '0, 2'd0, 0, '0);
      if (is_dsyn(i)) exp_es = es;
      if (is_mtag(i)) exp_ms = ms;
      check("R1 sticky set", 64'(sw_rd_data[51:33]), 64'(1) << i);
      check("R3 data syndrome", 64'(sw_rd_data[8:0]), 64'(exp_es));
      check("R3 tag syndrome", 64'(sw_rd_data[19:16]), 64'(exp_ms));
      check("R8 unlocked capture", 64'(fault_addr), 64'(addr_of(i, 1)));
      check("R11 irq set", 64'(irq), 64'h1);
      snap = sw_rd_data;
      wr(64'h0);
      check("R2 zero write", sw_rd_data, snap);
      wr(64'h0000_0000_000F_01FF);
      check("R3 syndrome write ignored", sw_rd_data, snap);
      wr(64'(1) << (33 + i));
      check("R2 clear one", 64'(sw_rd_data[51:33]), 64'h0);
      check("R11 irq clear", 64'(irq), 64'h0);
    end

    // every ordered pair: priority overwrite and multiple-error rule
    for (int i = 0; i < 19; i++) begin
      for (int j = 0; j < 19; j++) begin
        logic [ADDR_W-1:0] ea;
        wr(ALL1);
        evt(i, addr_of(i, 2));
        evt(j, addr_of(j, 3));
        ea = (cls(j) > cls(i)) ? addr_of(j, 3) : addr_of(i, 2);
        check("R8 priority", 64'(fault_addr), 64'(ea));
        if (i == j) check("R4 R5 repeat flag", 64'(sw_rd_data[53]), 64'(!is_hw(i)));
        else        check("R5 different types", 64'(sw_rd_data[53]), 64'h0);
      end
    end

    // R9 unlock on owner clear only
    wr(ALL1);
    evt(1, addr_of(1, 4));
    evt(0, addr_of(0, 4));
    wr(64'(1) << 33);
    check("R9 other clear keeps lock", 64'(fault_addr), 64'(addr_of(1, 4)));
    evt(3, addr_of(3, 4));
    check("R9 still locked", 64'(fault_addr), 64'(addr_of(1, 4)));
    wr(64'(1) << 34);
    check("R9 value held", 64'(fault_addr), 64'(addr_of(1, 4)));
    evt(5, addr_of(5, 4));
    check("R9 unlocked with bits set", 64'(fault_addr), 64'(addr_of(5, 4)));
    check("R9 other sticky remains", 64'(sw_rd_data[36]), 64'h1);

    // R10 event and clear of same bit together
    wr(ALL1);
    evt(2, addr_of(2, 5));
    step(1, 2, addr_of(2, 6), 4'h0, 9'h0, 0, 0, '0, 2'd0, 1, 64'(1) << 35);
    check("R10 bit kept", 64'(sw_rd_data[35]), 64'h1);
    check("R10 capture follows", 64'(fault_addr), 64'(addr_of(2, 6)));
    evt(0, addr_of(0, 6));
    check("R10 relocked", 64'(fault_addr), 64'(addr_of(2, 6)));

    // R6 transaction drop
    wr(ALL1);
    step(1, 0, addr_of(0, 7), 4'h0, 9'h0, 0, 1, 4'd5, 2'd0, 0, '0);
    step(1, 1, addr_of(1, 7), 4'h0, 9'h0, 0, 1, 4'd5, 2'd2, 0, '0);
    check("R6 dropped sticky", 64'(sw_rd_data[34]), 64'h0);
    check("R6 dropped addr", 64'(fault_addr), 64'(addr_of(0, 7)));
    step(1, 1, addr_of(1, 8), 4'h0, 9'h0, 0, 1, 4'd5, 2'd0, 0, '0);
    check("R6 new txn logged", 64'(fault_addr), 64'(addr_of(1, 8)));
    step(1, 1, addr_of(1, 9), 4'h0, 9'h0, 0, 1, 4'd6, 2'd1, 0, '0);
    check("R6 other tag sets flag", 64'(sw_rd_data[53]), 64'h1);

    // R7 privilege capture
    wr(ALL1);
    step(1, 2, addr_of(2, 9), 4'h0, 9'h0, 1, 0, '0, 2'd0, 0, '0);
    check("R7 priv high", 64'(sw_rd_data[52]), 64'h1);
    step(1, 3, addr_of(3, 9), 4'h0, 9'h0, 0, 0, '0, 2'd0, 0, '0);
    check("R7 priv low", 64'(sw_rd_data[52]), 64'h0);
    step(1, 3, addr_of(3, 9), 4'h0, 9'h0, 1, 0, '0, 2'd0, 0, '0);
    wr(64'(1) << 52);
    check("R2 priv clear", 64'(sw_rd_data[52]), 64'h0);

    // R11 enable gating
    irq_en = 1'b0; #1;
    check("R11 masked", 64'(irq), 64'h0);
    irq_en = 1'b1; #1;
    check("R11 unmasked", 64'(irq), 64'h1);

    // R1 out-of-range types ignored
    snap = sw_rd_data; asnap = fault_addr;
    for (int t = 19; t < 32; t++) begin
      evt(t, addr_of(t, 10));
      check("R1 out of range status", sw_rd_data, snap);
      check("R1 out of range addr", 64'(fault_addr), 64'(asnap));
    end

    // R12 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset clears status", sw_rd_data, 64'h0);
    check("R12 reset clears addr", 64'(fault_addr), 64'h0);
    evt(0, addr_of(0, 11));
    check("R12 unlocked after reset", 64'(fault_addr), 64'(addr_of(0, 11)));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule